// File: doc/BRIEF.md
# Index/Data Port Real-Time-Clock Register Bank

This block is a small real-time-clock register file that sits behind two byte-wide ports. A write to the index port latches a register number. The data port then reaches that register: its read data shows the selected register continuously, and a data write stores into it. The bank keeps seconds, minutes, hours, day of month, month and a two-digit year. It also has two status registers. One status register reports that an update is in progress. The other chooses between BCD and binary encoding and between 12-hour and 24-hour hours.

Time advances from a one-pulse-per-second tick. Each tick first raises the update-in-progress flag for a fixed number of clock cycles, and then commits one second, with carries rippling up through the date. All counting is done in binary inside the block. Encoding into the selected format happens only when a value is read, and decoding from the current format happens when a value is written. The top bit of every index write is kept separately and driven out as a mask for the non-maskable interrupt.

Top module: `rtc_idxbank`

## Requirements
- R1: The index port latches bus_wdata[6:0] as the selected register. A data write stores into that register, and bus_rdata shows it. The addresses are 0x00 seconds, 0x02 minutes, 0x04 hours, 0x07 day of month, 0x08 month, 0x09 year, 0x0A status A and 0x0B status B.
- R2: Bit 7 of every index write is latched and driven on nmi_mask until the next index write.
- R3: Status B is fully readable and writable. When bit 2 is set, fields are read and written in binary. When it is clear, fields use packed BCD (tens in [7:4], units in [3:0]). When bit 1 is set, the hour is 0–23.
- R4: When status B bit 1 is clear, the hour byte holds 1–12 in the current encoding, with bit 7 set for PM. 12 with bit 7 clear is midnight (hour 0), and 12 with bit 7 set is noon.
- R5: Status A bit 7 reads as the update-in-progress flag and ignores writes. Status A bits 6:0 are plain read/write storage.
- R6: When a tick arrives while no update is in progress, the flag is raised for exactly UIP_CYCLES cycles. The fields advance at the clock edge on which the flag drops. A tick that arrives while the flag is high is ignored.
- R7: A commit adds one second. Seconds and minutes wrap from 59 to 0, hours from 23 to 0, months from 12 to 1 and years from 99 to 0. Each wrap carries into the next field up.
- R8: The day of month wraps to 1 after 30 in April, June, September and November, and after 31 in the other months. February wraps after 29 when year mod 4 is 0 (year 00 included) and after 28 otherwise.
- R9: A selected index with no register behind it reads 0x00, and data writes to it change nothing.
- R10: After reset the bank holds 00:00:00, day 1, month 1, year 00. Status B is 0x02 (24-hour, BCD), status A is 0x00, the index is 0 and nmi_mask is low.
- R11: If a data write to a time or date field falls in the commit cycle, the written value wins for that field. All other fields still advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second that starts an update |
| idx_wr | input | 1 | Index-port write strobe |
| data_wr | input | 1 | Data-port write strobe |
| bus_wdata | input | 8 | Write byte shared by both ports |
| bus_rdata | output | 8 | Encoded contents of the selected register |
| nmi_mask | output | 1 | Latched bit 7 of the last index write |

## Verification
Two functions can fall in the same cycle: the tick-driven commit of the time fields, and a software data write to one of those fields. The bench selects the minute register before it sends a tick. It then counts cycles from the tick so that a minute write is presented exactly on the commit edge. The write is judged correct when the minute register shows the written value rather than the incremented one, while the seconds still roll over and the hour stays as it was. The same cycle count also places the two samples of the update flag, one on each side of its falling edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [6:0] A_SEC  = 7'h00;
  localparam logic [6:0] A_MIN  = 7'h02;
  localparam logic [6:0] A_HOUR = 7'h04;
  localparam logic [6:0] A_DAY  = 7'h07;
  localparam logic [6:0] A_MON  = 7'h08;
  localparam logic [6:0] A_YEAR = 7'h09;
  localparam logic [6:0] A_STA  = 7'h0A;
  localparam logic [6:0] A_STB  = 7'h0B;

  localparam int B_H24 = 1;
  localparam int B_BIN = 2;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;
  localparam int NFIELD = 6;

  typedef struct packed {
    logic [6:0] year;
    logic [3:0] mon;
    logic [4:0] day;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } rtc_time_t;

  function automatic logic is_mapped(input logic [6:0] a);
    case (a)
      A_SEC, A_MIN, A_HOUR, A_DAY, A_MON, A_YEAR, A_STA, A_STB: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [6:0] from_bcd(input logic [7:0] b);
    logic [7:0] s;
    s = 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
    return s[6:0];
  endfunction

  function automatic logic [7:0] enc_field(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : to_bcd(v);
  endfunction

  function automatic logic [6:0] dec_field(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : from_bcd(b);
  endfunction

  function automatic logic [7:0] enc_hour(input logic [4:0] h, input logic bin,
                                          input logic h24);
    logic [4:0] h12;
    logic       pm;
    logic [7:0] e;
    if (h24) return enc_field({2'b00, h}, bin);
    pm  = (h >= 5'd12);
    h12 = (h == 5'd0) ? 5'd12 : ((h > 5'd12) ? h - 5'd12 : h);
    e   = enc_field({2'b00, h12}, bin);
    return {pm, e[6:0]};
  endfunction

  function automatic logic [4:0] dec_hour(input logic [7:0] b, input logic bin,
                                          input logic h24);
    logic [6:0] v;
    logic [4:0] base;
    if (h24) begin
      v = dec_field(b, bin);
      return v[4:0];
    end
    v    = dec_field({1'b0, b[6:0]}, bin);
    base = (v == 7'd12) ? 5'd0 : v[4:0];
    return b[7] ? base + 5'd12 : base;
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] m, input logic leap);
    case (m)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
  parameter int UIP_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic uip,
  output logic commit
);
  localparam int CW = (UIP_CYCLES > 1) ? $clog2(UIP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(UIP_CYCLES - 1);

  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (tick) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (cnt == LAST) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign uip    = busy;
  assign commit = busy && (cnt == LAST);
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [NFIELD-1:0] wr_mask,
  input  rtc_time_t         wr_val,
  output rtc_time_t         cur
);
  rtc_time_t  adv;
  rtc_time_t  nxt;
  logic [4:0] dim;
  logic       c_min, c_hr, c_day, c_mon, c_yr;

  assign dim = month_days(cur.mon, cur.year[1:0] == 2'b00);

  always_comb begin
    adv   = cur;
    c_min = (cur.sec >= 6'd59);
    c_hr  = c_min && (cur.min >= 6'd59);
    c_day = c_hr && (cur.hour >= 5'd23);
    c_mon = c_day && (cur.day >= dim);
    c_yr  = c_mon && (cur.mon >= 4'd12);
    adv.sec = c_min ? 6'd0 : cur.sec + 6'd1;
    if (c_min) adv.min  = c_hr  ? 6'd0 : cur.min + 6'd1;
    if (c_hr)  adv.hour = c_day ? 5'd0 : cur.hour + 5'd1;
    if (c_day) adv.day  = c_mon ? 5'd1 : cur.day + 5'd1;
    if (c_mon) adv.mon  = c_yr  ? 4'd1 : cur.mon + 4'd1;
    if (c_yr)  adv.year = (cur.year >= 7'd99) ? 7'd0 : cur.year + 7'd1;
  end

  always_comb begin
    nxt = commit ? adv : cur;
    if (wr_mask[F_SEC])  nxt.sec  = wr_val.sec;
    if (wr_mask[F_MIN])  nxt.min  = wr_val.min;
    if (wr_mask[F_HOUR]) nxt.hour = wr_val.hour;
    if (wr_mask[F_DAY])  nxt.day  = wr_val.day;
    if (wr_mask[F_MON])  nxt.mon  = wr_val.mon;
    if (wr_mask[F_YEAR]) nxt.year = wr_val.year;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur.sec  <= 6'd0;
      cur.min  <= 6'd0;
      cur.hour <= 5'd0;
      cur.day  <= 5'd1;
      cur.mon  <= 4'd1;
      cur.year <= 7'd0;
    end else begin
      cur <= nxt;
    end
  end
endmodule

// File: rtl/rtc_wr_decode.sv
module rtc_wr_decode
  import rtc_pkg::*;
(
  input  logic              wr_en,
  input  logic [6:0]        sel,
  input  logic [7:0]        wdata,
  input  logic [7:0]        stb,
  output logic [NFIELD-1:0] wr_mask,
  output rtc_time_t         wr_val
);
  logic       bin;
  logic       h24;
  logic [6:0] v;

  assign bin = stb[B_BIN];
  assign h24 = stb[B_H24];
  assign v   = dec_field(wdata, bin);

  always_comb begin
    wr_mask = '0;
    wr_val  = '0;
    if (wr_en) begin
      case (sel)
        A_SEC:  begin wr_mask[F_SEC]  = 1'b1; wr_val.sec  = v[5:0]; end
        A_MIN:  begin wr_mask[F_MIN]  = 1'b1; wr_val.min  = v[5:0]; end
        A_HOUR: begin wr_mask[F_HOUR] = 1'b1; wr_val.hour = dec_hour(wdata, bin, h24); end
        A_DAY:  begin wr_mask[F_DAY]  = 1'b1; wr_val.day  = v[4:0]; end
        A_MON:  begin wr_mask[F_MON]  = 1'b1; wr_val.mon  = v[3:0]; end
        A_YEAR: begin wr_mask[F_YEAR] = 1'b1; wr_val.year = v; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rtc_reg_view.sv
module rtc_reg_view
  import rtc_pkg::*;
(
  input  rtc_time_t  cur,
  input  logic [6:0] sel,
  input  logic [7:0] stb,
  input  logic [6:0] sta_low,
  input  logic       uip,
  output logic [7:0] rdata
);
  logic bin;
  assign bin = stb[B_BIN];

  always_comb begin
    case (sel)
      A_SEC:  rdata = enc_field({1'b0, cur.sec}, bin);
      A_MIN:  rdata = enc_field({1'b0, cur.min}, bin);
      A_HOUR: rdata = enc_hour(cur.hour, bin, stb[B_H24]);
      A_DAY:  rdata = enc_field({2'b00, cur.day}, bin);
      A_MON:  rdata = enc_field({3'b000, cur.mon}, bin);
      A_YEAR: rdata = enc_field(cur.year, bin);
      A_STA:  rdata = {uip, sta_low};
      A_STB:  rdata = stb;
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_idxbank.sv
module rtc_idxbank
  import rtc_pkg::*;
#(
  parameter int UIP_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       idx_wr,
  input  logic       data_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       nmi_mask
);
  logic [6:0]        sel_idx;
  logic              nmi_q;
  logic [6:0]        sta_low;
  logic [7:0]        stb;
  logic              uip;
  logic              commit;
  logic [NFIELD-1:0] wr_mask;
  rtc_time_t         wr_val;
  rtc_time_t         cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_idx <= 7'd0;
      nmi_q   <= 1'b0;
      sta_low <= 7'd0;
      stb     <= 8'h02;
    end else begin
      if (idx_wr) begin
        sel_idx <= bus_wdata[6:0];
        nmi_q   <= bus_wdata[7];
      end
      if (data_wr && sel_idx == A_STA) sta_low <= bus_wdata[6:0];
      if (data_wr && sel_idx == A_STB) stb     <= bus_wdata;
    end
  end

  assign nmi_mask = nmi_q;

  rtc_update_seq #(.UIP_CYCLES(UIP_CYCLES)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_1hz),
    .uip    (uip),
    .commit (commit)
  );

  rtc_wr_decode u_wdec (
    .wr_en   (data_wr),
    .sel     (sel_idx),
    .wdata   (bus_wdata),
    .stb     (stb),
    .wr_mask (wr_mask),
    .wr_val  (wr_val)
  );

  rtc_time_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (commit),
    .wr_mask (wr_mask),
    .wr_val  (wr_val),
    .cur     (cur)
  );

  rtc_reg_view u_view (
    .cur     (cur),
    .sel     (sel_idx),
    .stb     (stb),
    .sta_low (sta_low),
    .uip     (uip),
    .rdata   (bus_rdata)
  );
endmodule

// File: rtl/rtc_idxbank_chk.sv
module rtc_idxbank_chk
  import rtc_pkg::*;
#(
  parameter int UIP_CYCLES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_1hz,
  input logic       idx_wr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       nmi_mask,
  input logic [6:0] sel_idx,
  input logic       uip,
  input logic       commit
);
  int run;

  always_ff @(posedge clk) begin
    if (!rst_n) run <= 0;
    else        run <= uip ? run + 1 : 0;
  end

  assert_nmi_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> nmi_mask == $past(bus_wdata[7]));

  assert_nmi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(nmi_mask));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mapped(sel_idx) |-> bus_rdata == 8'h00);

  assert_uip_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_idx == A_STA) |-> bus_rdata[7] == uip);

  assert_uip_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !uip) |=> uip);

  assert_uip_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run <= UIP_CYCLES);

  assert_commit_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> uip ##1 !uip);
endmodule

bind rtc_idxbank rtc_idxbank_chk #(.UIP_CYCLES(UIP_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_1hz  (tick_1hz),
  .idx_wr    (idx_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .nmi_mask  (nmi_mask),
  .sel_idx   (sel_idx),
  .uip       (uip),
  .commit    (commit)
);

// File: tb/rtc_idxbank_bench.sv
module rtc_idxbank_bench;
  localparam int UIPN = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       idx_wr = 1'b0;
  logic       data_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       nmi_mask;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_idxbank #(.UIP_CYCLES(UIPN)) u_rtc_idxbank (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .idx_wr(idx_wr),
    .data_wr(data_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nmi_mask(nmi_mask)
  );

  // {status B, hour in, min in, sec in, hour exp, min exp, sec exp}
  localparam logic [55:0] VEC [0:5] = '{
    56'h02_23_59_59_00_00_00,
    56'h06_0A_3B_3B_0B_00_00,
    56'h00_11_59_59_92_00_00,
    56'h04_8B_3B_3B_0C_00_00,
    56'h02_12_34_56_12_34_57,
    56'h00_12_00_59_12_01_00
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic idx_write(input logic [7:0] v);
    @(negedge clk); idx_wr = 1'b1; bus_wdata = v;
    @(negedge clk); idx_wr = 1'b0;
  endtask

  task automatic dat_write(input logic [7:0] v);
    @(negedge clk); data_wr = 1'b1; bus_wdata = v;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic wreg(input logic [6:0] a, input logic [7:0] v);
    idx_write({1'b0, a});
    dat_write(v);
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] v);
    idx_write({1'b0, a});
    v = bus_rdata;
  endtask

  task automatic pulse();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic tick_full();
    pulse();
    repeat (UIPN + 2) @(negedge clk);
  endtask

  task automatic date_roll(input logic [7:0] d, input logic [7:0] m, input logic [7:0] y,
                           input logic [7:0] ed, input logic [7:0] em, input logic [7:0] ey);
    logic [7:0] v;
    wreg(7'h0B, 8'h02);
    wreg(7'h07, d); wreg(7'h08, m); wreg(7'h09, y);
    wreg(7'h04, 8'h23); wreg(7'h02, 8'h59); wreg(7'h00, 8'h59);
    tick_full();
    rd(7'h07, v); chk("R8 day", v, ed);
    rd(7'h08, v); chk("R7 month", v, em);
    rd(7'h09, v); chk("R7 year", v, ey);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 nmi_mask", {7'd0, nmi_mask}, 8'h00);
    chk("R10 sel0 seconds", bus_rdata, 8'h00);
    rd(7'h07, v); chk("R10 day", v, 8'h01);
    rd(7'h08, v); chk("R10 month", v, 8'h01);
    rd(7'h0B, v); chk("R10 status B", v, 8'h02);
    rd(7'h0A, v); chk("R10 status A", v, 8'h00);

    // Table walk: R3 R4 R7
    for (int i = 0; i < 6; i++) begin
      logic [55:0] e;
      e = VEC[i];
      wreg(7'h0B, e[55:48]);
      wreg(7'h04, e[47:40]);
      wreg(7'h02, e[39:32]);
      wreg(7'h00, e[31:24]);
      tick_full();
      rd(7'h04, v); chk("R4 hour", v, e[23:16]);
      rd(7'h02, v); chk("R3 minute", v, e[15:8]);
      rd(7'h00, v); chk("R7 second", v, e[7:0]);
    end

    // R1 plain store and read back in BCD
    wreg(7'h0B, 8'h02);
    wreg(7'h09, 8'h47);
    rd(7'h09, v); chk("R1 year store", v, 8'h47);
    // R3 same value seen in binary after format change
    wreg(7'h0B, 8'h06);
    rd(7'h09, v); chk("R3 binary view", v, 8'h2F);
    rd(7'h0B, v); chk("R3 status B readback", v, 8'h06);

    // R2 NMI mask bit
    idx_write(8'h80);
    chk("R2 nmi set", {7'd0, nmi_mask}, 8'h01);
    idx_write(8'h09);
    chk("R2 nmi clear", {7'd0, nmi_mask}, 8'h00);
    chk("R1 index ignores bit7", bus_rdata, 8'h2F);

    // R9 unmapped index
    wreg(7'h01, 8'h55);
    chk("R9 unmapped read", bus_rdata, 8'h00);
    rd(7'h0C, v); chk("R9 unmapped 0x0C", v, 8'h00);
    rd(7'h0B, v); chk("R9 status B untouched", v, 8'h06);
    rd(7'h00, v); chk("R9 seconds untouched", v, 8'h00);

    // R5 status A writes and the update flag
    wreg(7'h0B, 8'h02);
    wreg(7'h00, 8'h30);
    wreg(7'h0A, 8'hFF);
    chk("R5 status A write", bus_rdata, 8'h7F);
    pulse();
    repeat (UIPN - 1) @(negedge clk);
    chk("R6 flag high last cycle", bus_rdata, 8'hFF);
    @(negedge clk);
    chk("R6 flag cleared", bus_rdata, 8'h7F);
    rd(7'h00, v); chk("R6 seconds advanced", v, 8'h31);

    // R6 tick during update ignored
    wreg(7'h00, 8'h10);
    pulse();
    repeat (2) @(negedge clk);
    pulse();
    repeat (UIPN + 4) @(negedge clk);
    rd(7'h00, v); chk("R6 second tick ignored", v, 8'h11);

    // R8 R7 date boundaries
    date_roll(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23);
    date_roll(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24);
    date_roll(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, 8'h00);
    date_roll(8'h30, 8'h04, 8'h10, 8'h01, 8'h05, 8'h10);
    date_roll(8'h30, 8'h05, 8'h10, 8'h31, 8'h05, 8'h10);
    date_roll(8'h31, 8'h12, 8'h99, 8'h01, 8'h01, 8'h00);

    // R11 write on the commit edge
    wreg(7'h0B, 8'h02);
    wreg(7'h00, 8'h59);
    wreg(7'h02, 8'h00);
    wreg(7'h04, 8'h05);
    idx_write(8'h02);
    pulse();
    repeat (UIPN - 1) @(negedge clk);
    data_wr = 1'b1; bus_wdata = 8'h45;
    @(negedge clk);
    data_wr = 1'b0;
    repeat (2) @(negedge clk);
    rd(7'h02, v); chk("R11 written minute wins", v, 8'h45);
    rd(7'h00, v); chk("R11 seconds still roll", v, 8'h00);
    rd(7'h04, v); chk("R11 hour unchanged", v, 8'h05);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule